// File: doc/BRIEF.md
# Lockout Key Debouncer

This block cleans up the level from one mechanical key switch. It samples the raw switch level on every clock edge and drives a debounced level. The first edge seen while the block is idle goes straight to the output, with no settling delay. After that, a lockout timer holds the output fixed until it has counted out its window, so any contact chatter in that window is dropped. The timer only counts up. It stops at its all-ones value and stays there, and the block is idle whenever the timer is full.

A key that is held down reads low and a released key reads high. The debounced level keeps the same polarity. A one-cycle toggle strobe marks each accepted change. The only parameter is the width of the lockout counter, so the block can be copied once for every key of a keyboard. The raw input is expected to be synchronised to the clock before it reaches this block. The reset input is asynchronous and active low. Inside the block it is released in step with the clock.

Top module: `keylock_debounce`

## Requirements
- R1: While reset is held and after it is released, `key_level` is 1 (released) and `key_toggle` is 0. The lockout timer starts full, so a differing raw level is accepted at the first edge after reset.
- R2: When the block is idle and `key_raw` differs from `key_level` at a clock edge, `key_level` takes the raw value at that same edge.
- R3: `key_toggle` is 1 for exactly the one cycle after an edge at which `key_level` changed. It is 0 at all other times.
- R4: Call the edge that accepts a change E0. The raw levels at edges E1 through E(2^CNT_W − 1) have no effect on `key_level`, whatever pattern they follow.
- R5: From edge E(2^CNT_W) onward, a raw level that differs from `key_level` is accepted at the first edge where it is present.
- R6: The lockout timer stops at its all-ones value and does not wrap. After any length of idle time, a change is accepted at once.
- R7: `key_level` takes the raw level it accepted without inversion: 0 means pressed and 1 means released. Both press and release are debounced the same way.
- R8: `CNT_W` sets the counter width, and both 3 and the default of 8 are supported. With CNT_W = 8 the lockout is 255 edges and the next change is accepted at edge 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| key_raw | input | 1 | Synchronised raw switch level (0 = pressed) |
| key_level | output | 1 | Debounced key level (0 = pressed, 1 = released) |
| key_toggle | output | 1 | One-cycle strobe after each accepted change |

## Verification
The main instance is built with CNT_W = 3, which makes the lockout window only seven edges long. This lets the bench try every return point of a bounce, from the first edge after a change to several edges past the end of the window, for both press and release. It also drives full chatter through the window. A second instance keeps the default width of 8, so the bench can confirm that the 255-edge lockout ends on the right edge.

// File: rtl/kld_pkg.sv
package kld_pkg;

  // Default lockout counter width.
  localparam int unsigned KLD_DEF_CNT_W = 8;

  // Flops in the reset release synchroniser.
  localparam int unsigned KLD_RST_STAGES = 2;

  // Key level encoding shared by the raw input and the debounced output.
  typedef enum logic {
    KEY_PRESSED  = 1'b0,
    KEY_RELEASED = 1'b1
  } key_lvl_e;

endpackage

// File: rtl/kld_reset_sync.sv
module kld_reset_sync
  import kld_pkg::*;
#(
  parameter int unsigned STAGES = KLD_RST_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[LAST];

endmodule

// File: rtl/kld_lockout_timer.sv
module kld_lockout_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic             ready,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_FULL = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ZERO = {CNT_W{1'b0}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             full;

  assign full = (cnt_q == CNT_FULL);

  // The counter runs until it is full and then stops there.
  // A restart sends it back to zero.
  always_comb begin
    cnt_en = restart | ~full;
    cnt_d  = cnt_q;
    if (restart)    cnt_d = CNT_ZERO;
    else if (!full) cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_FULL;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ready = full;
  assign cnt   = cnt_q;

endmodule

// File: rtl/kld_edge_gate.sv
module kld_edge_gate
  import kld_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic ready,
  output logic accept,
  output logic level,
  output logic toggle
);

  logic level_q;
  logic level_d;
  logic toggle_q;
  logic toggle_d;

  always_comb begin
    accept   = ready & (raw != level_q);
    level_d  = accept ? raw : level_q;
    toggle_d = accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      level_q <= KEY_RELEASED;
    else if (accept) level_q <= level_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) toggle_q <= 1'b0;
    else        toggle_q <= toggle_d;
  end

  assign level  = level_q;
  assign toggle = toggle_q;

endmodule

// File: rtl/keylock_debounce.sv
module keylock_debounce
  import kld_pkg::*;
#(
  parameter int unsigned CNT_W = KLD_DEF_CNT_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic key_raw,
  output logic key_level,
  output logic key_toggle
);

  logic             rst_int_n;
  logic             lock_ready;
  logic             accept;
  logic [CNT_W-1:0] lock_cnt;

  kld_reset_sync #(
    .STAGES(KLD_RST_STAGES)
  ) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  kld_lockout_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .restart (accept),
    .ready   (lock_ready),
    .cnt     (lock_cnt)
  );

  kld_edge_gate u_gate (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .raw    (key_raw),
    .ready  (lock_ready),
    .accept (accept),
    .level  (key_level),
    .toggle (key_toggle)
  );

endmodule

// File: rtl/kld_checker.sv
module kld_checker #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             key_raw,
  input logic             key_level,
  input logic             key_toggle,
  input logic [CNT_W-1:0] lock_cnt
);

  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  assert_take_raw_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_cnt == FULL && key_raw != key_level) |=> (key_level == $past(key_raw)));

  assert_hold_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_cnt != FULL) |=> $stable(key_level));

  assert_strobe_on_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (key_level != $past(key_level)) |-> key_toggle);

  assert_strobe_only_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    key_toggle |-> (key_level != $past(key_level)));

  assert_restart_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    key_toggle |-> (lock_cnt == '0));

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_cnt != FULL) |=> (lock_cnt == CNT_W'($past(lock_cnt) + 1'b1)));

  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_cnt == FULL && key_raw == key_level) |=> (lock_cnt == FULL));

endmodule

bind keylock_debounce kld_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .key_raw    (key_raw),
  .key_level  (key_level),
  .key_toggle (key_toggle),
  .lock_cnt   (lock_cnt)
);

// File: tb/keylock_debounce_tb.sv
module keylock_debounce_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SMALL_W    = 3;
  localparam int SMALL_MAX  = (1 << SMALL_W) - 1;
  localparam int WIDE_MAX   = 255;

  logic clk;
  logic rst_n;
  logic raw;
  logic raw_w;
  logic lvl;
  logic tgl;
  logic lvl_w;
  logic tgl_w;

  int n_chk;
  int n_fail;

  keylock_debounce #(.CNT_W(SMALL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .key_raw(raw), .key_level(lvl), .key_toggle(tgl)
  );

  keylock_debounce u_wide (
    .clk(clk), .rst_n(rst_n), .key_raw(raw_w), .key_level(lvl_w), .key_toggle(tgl_w)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Drive before the next edge, then sample shortly after it.
  task automatic step(input logic v);
    @(negedge clk);
    raw = v;
    @(posedge clk);
    #1;
  endtask

  task automatic settle(input logic v);
    for (int i = 0; i < 2*SMALL_MAX + 4; i++) step(v);
  endtask

  // Make a change at E0. The raw level goes back to base from edge d on.
  task automatic sweep(input logic base, input int d);
    int acc;
    settle(base);
    step(~base);
    check("R2 immediate accept", lvl, ~base);
    check("R3 strobe on accept", tgl, 1'b1);
    acc = (d > SMALL_MAX) ? d : SMALL_MAX + 1;
    for (int k = 1; k <= acc + 2; k++) begin
      step((k >= d) ? base : ~base);
      if (k < acc) check("R4 lockout holds", lvl, ~base);
      else         check("R5 accepted after lockout", lvl, base);
      check("R3 strobe one cycle", tgl, (k == acc));
    end
  endtask

  initial begin
    n_chk  = 0;
    n_fail = 0;
    rst_n  = 1'b0;
    raw    = 1'b1;
    raw_w  = 1'b1;
    #(CLK_PERIOD*3 + 1);
    check("R1 reset level", lvl, 1'b1);
    check("R1 reset toggle", tgl, 1'b0);
    check("R1 reset level wide", lvl_w, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b1);
    check("R1 level after release", lvl, 1'b1);
    check("R1 toggle after release", tgl, 1'b0);
    // The timer starts full, so a press is taken at the first edge.
    step(1'b0);
    check("R1 first press accepted", lvl, 1'b0);
    check("R7 pressed reads low", lvl, 1'b0);

    // Every return point of the bounce, for press then release.
    for (int d = 1; d <= SMALL_MAX + 3; d++) sweep(1'b1, d);
    for (int d = 1; d <= SMALL_MAX + 3; d++) sweep(1'b0, d);

    // Chatter on every edge of the window, ending on the accepted level.
    settle(1'b1);
    step(1'b0);
    check("R7 press low", lvl, 1'b0);
    for (int k = 1; k <= SMALL_MAX; k++) begin
      step(k[0]);
      check("R4 chatter ignored", lvl, 1'b0);
      check("R4 no strobe in chatter", tgl, 1'b0);
    end
    step(1'b0);
    check("R4 settled same level", lvl, 1'b0);
    check("R3 no strobe without change", tgl, 1'b0);

    // A long idle time must not make the timer wrap.
    for (int i = 0; i < 10*SMALL_MAX; i++) step(1'b0);
    step(1'b1);
    check("R6 accept after long idle", lvl, 1'b1);
    check("R7 release reads high", lvl, 1'b1);

    // Default width: a 255-edge lockout.
    begin
      logic held;
      held = 1'b1;
      @(negedge clk); raw_w = 1'b0; @(posedge clk); #1;
      check("R8 wide press accepted", lvl_w, 1'b0);
      for (int k = 1; k <= WIDE_MAX; k++) begin
        @(negedge clk); raw_w = 1'b1; @(posedge clk); #1;
        if (lvl_w !== 1'b0) held = 1'b0;
      end
      check("R8 wide lockout holds 255 edges", held, 1'b1);
      @(negedge clk); @(posedge clk); #1;
      check("R8 wide accepted at edge 256", lvl_w, 1'b1);
      check("R8 wide strobe", tgl_w, 1'b1);
    end

    finish_run();
  end

  initial begin
    #(CLK_PERIOD*200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule